// File: doc/BRIEF.md
# SPI Two-Stage Baud Generator

This block makes the serial clock timing for an SPI master out of a faster main clock. The main clock first passes through a power-of-two prescaler that divides by 2^(DIV+1), with DIV from 0 to 3. An even divider then divides that intermediate rate by 2*(BRG+1), with BRG limited to 4..63. The output is not a clock. It is a pair of one-cycle strobes that mark the leading and trailing edges of SCK. A shifter elsewhere uses them to launch and capture bits.

A small sequential calculator sets the two fields. It takes a requested divide ratio, meaning main clock frequency over wanted SCK frequency. It tries DIV = 0, 1, 2, 3 in turn, one per cycle. For each DIV it forms BRG+1 = ratio / (4 << DIV), which is a right shift by DIV+2. It keeps the first DIV whose quotient is no larger than 64. A request that is too fast is pinned to the fastest legal setting. A request that is too slow is pinned to the slowest. The fastest reachable SCK is the main clock divided by 20, and the slowest is the main clock divided by 2048.

Top module: `spi_baud_gen`

## Requirements
- R1: After reset `brg` is 4, `div` is 0, `done` is low, and no strobe is issued.
- R2: A request is accepted by a one-cycle `start` while the calculator is idle. The calculator selects the lowest DIV in 0..3 for which q = ratio >> (DIV+2) satisfies q <= 64, and sets BRG = q - 1.
- R3: When ratio >> 2 is below 5, the result is BRG = 4 and DIV = 0.
- R4: When ratio >> 5 is above 64, the result is DIV = 3 and BRG = 63.
- R5: `done` is high for exactly one cycle, in the cycle where the new fields first appear on `brg` and `div`. It appears DIV+1 cycles after the cycle in which `start` was sampled, where DIV is the chosen value.
- R6: A `start` that arrives while a search is running is ignored. The running search produces one `done` and its own result.
- R7: While `en` is high, strobes alternate leading, trailing, leading, and so on. Consecutive strobes are (BRG+1)*2^(DIV+1) cycles apart. `sck_lead` and `sck_trail` are never high together.
- R8: While `en` is low, neither strobe is issued.
- R9: Each field update, marked by `done`, restarts the generator. With `en` held high, the first strobe after the update is a leading strobe, issued (BRG+1)*2^(DIV+1)+1 cycles after the `done` cycle.
- R10: A ratio of 20 gives a full SCK period of 20 main clocks, and a ratio of 2048 gives a full period of 2048 main clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Runs the strobe generator while high |
| start | input | 1 | One-cycle request to compute new fields |
| ratio | input | RATIO_W | Requested divide ratio, main clock over SCK |
| sck_lead | output | 1 | One-cycle leading-edge strobe |
| sck_trail | output | 1 | One-cycle trailing-edge strobe |
| brg | output | 6 | Selected even-divider field, 4..63 |
| div | output | 2 | Selected prescaler field, 0..3 |
| done | output | 1 | One-cycle pulse when new fields are valid |

## Verification
The bench builds the block with the default RATIO_W of 16. That width reaches ratios far past the slow clamp, for example 60000, as well as the exact edges 19/20, 259/260 and 2079/2080, where the selection changes or clamps. Those ratios drive every search length from one to four cycles. The strobe spacing is measured at the fastest setting, at a mid setting and at the slowest setting, so the prescaler and the even divider are each exercised at both ends of their range.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int DIV_W  = 2;
  localparam int BRG_W  = 6;
  localparam int BRG_LO = 4;
  localparam int BRG_HI = 63;
  localparam int DIV_HI = (1 << DIV_W) - 1;
  localparam int PRE_W  = DIV_HI + 1;

  typedef enum logic {
    CALC_IDLE,
    CALC_SEARCH
  } calc_state_e;
endpackage

// File: rtl/baud_calc.sv
module baud_calc
  import spi_baud_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  output logic [BRG_W-1:0]   brg,
  output logic [DIV_W-1:0]   div,
  output logic               done
);
  localparam logic [RATIO_W-1:0] FAST_LIM = RATIO_W'(BRG_LO + 1);
  localparam logic [RATIO_W-1:0] SLOW_LIM = RATIO_W'(BRG_HI + 1);

  calc_state_e        state_q, state_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d;
  logic [DIV_W-1:0]   try_q, try_d;
  logic [BRG_W-1:0]   brg_q, brg_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               done_q, done_d;
  logic [RATIO_W-1:0] quot;
  logic [RATIO_W-1:0] quot_m1;

  // BRG+1 candidate: ratio / (4 << try) is a shift by try+2
  assign quot    = ratio_q >> ({1'b0, try_q} + 3'd2);
  assign quot_m1 = quot - 1'b1;

  always_comb begin
    state_d = state_q;
    ratio_d = ratio_q;
    try_d   = try_q;
    brg_d   = brg_q;
    div_d   = div_q;
    done_d  = 1'b0;
    case (state_q)
      CALC_IDLE: begin
        if (start) begin
          ratio_d = ratio;
          try_d   = '0;
          state_d = CALC_SEARCH;
        end
      end
      CALC_SEARCH: begin
        if (try_q == '0 && quot < FAST_LIM) begin
          brg_d   = BRG_W'(BRG_LO);
          div_d   = '0;
          done_d  = 1'b1;
          state_d = CALC_IDLE;
        end else if (quot <= SLOW_LIM) begin
          brg_d   = quot_m1[BRG_W-1:0];
          div_d   = try_q;
          done_d  = 1'b1;
          state_d = CALC_IDLE;
        end else if (try_q == DIV_W'(DIV_HI)) begin
          brg_d   = BRG_W'(BRG_HI);
          div_d   = DIV_W'(DIV_HI);
          done_d  = 1'b1;
          state_d = CALC_IDLE;
        end else begin
          try_d = try_q + 1'b1;
        end
      end
      default: state_d = CALC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CALC_IDLE;
      ratio_q <= '0;
      try_q   <= '0;
      brg_q   <= BRG_W'(BRG_LO);
      div_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ratio_q <= ratio_d;
      try_q   <= try_d;
      brg_q   <= brg_d;
      div_q   <= div_d;
      done_q  <= done_d;
    end
  end

  assign brg  = brg_q;
  assign div  = div_q;
  assign done = done_q;

  // R2: the even-divider field never leaves its legal range
  p_brg_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (brg_q >= BRG_W'(BRG_LO)) && (brg_q <= BRG_W'(BRG_HI)));

  // R5: done is a single-cycle pulse
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R3: a too-fast request lands on the fastest setting
  p_fast_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CALC_SEARCH && try_q == '0 && quot < FAST_LIM)
    |=> (brg_q == BRG_W'(BRG_LO) && div_q == '0 && done_q));

  // R4: a too-slow request lands on the slowest setting
  p_slow_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CALC_SEARCH && try_q == DIV_W'(DIV_HI) && quot > SLOW_LIM)
    |=> (brg_q == BRG_W'(BRG_HI) && div_q == DIV_W'(DIV_HI)));

  // R6: the request held during a search is not replaced
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CALC_SEARCH) |=> $stable(ratio_q));
endmodule

// File: rtl/baud_strobe.sv
module baud_strobe
  import spi_baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic [BRG_W-1:0] brg,
  input  logic [DIV_W-1:0] div,
  output logic             sck_lead,
  output logic             sck_trail
);
  logic [PRE_W-1:0] pre_q, pre_d;
  logic [BRG_W-1:0] cnt_q, cnt_d;
  logic             phase_q, phase_d;
  logic             lead_q, lead_d;
  logic             trail_q, trail_d;
  logic [PRE_W:0]   span;
  logic [PRE_W-1:0] pre_last;
  logic             tick;
  logic             term;

  assign span     = (PRE_W + 1)'(1) << ({1'b0, div} + 3'd1);
  assign pre_last = PRE_W'(span - 1'b1);
  assign tick     = en && (pre_q == pre_last);
  assign term     = tick && (cnt_q == brg);

  always_comb begin
    if (!en || restart) begin
      pre_d   = '0;
      cnt_d   = '0;
      phase_d = 1'b0;
      lead_d  = 1'b0;
      trail_d = 1'b0;
    end else begin
      pre_d   = tick ? '0 : pre_q + 1'b1;
      cnt_d   = term ? '0 : (tick ? cnt_q + 1'b1 : cnt_q);
      phase_d = term ? ~phase_q : phase_q;
      lead_d  = term && !phase_q;
      trail_d = term && phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      phase_q <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign sck_lead  = lead_q;
  assign sck_trail = trail_q;

  // R7: the two edge strobes never coincide
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_q && trail_q));

  // R8: a disabled cycle issues no strobe
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lead_q && !trail_q));

  // R9: a field update suppresses any strobe in the following cycle
  p_restart_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!lead_q && !trail_q));
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_pkg::*;
#(
  parameter int RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               start,
  input  logic [RATIO_W-1:0] ratio,
  output logic               sck_lead,
  output logic               sck_trail,
  output logic [BRG_W-1:0]   brg,
  output logic [DIV_W-1:0]   div,
  output logic               done
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  baud_calc #(.RATIO_W(RATIO_W)) u_calc (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .ratio (ratio),
    .brg   (brg),
    .div   (div),
    .done  (done)
  );

  baud_strobe u_strobe (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en        (en),
    .restart   (done),
    .brg       (brg),
    .div       (div),
    .sck_lead  (sck_lead),
    .sck_trail (sck_trail)
  );
endmodule

// File: tb/spi_baud_gen_test.sv
`timescale 1ns/1ps
module spi_baud_gen_test;
  localparam int RW = 16;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic          start;
  logic [RW-1:0] ratio;
  logic          sck_lead, sck_trail, done;
  logic [5:0]    brg;
  logic [1:0]    div;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  spi_baud_gen #(.RATIO_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .ratio(ratio),
    .sck_lead(sck_lead), .sck_trail(sck_trail), .brg(brg), .div(div),
    .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected fields from the search rule (R2, R3, R4)
  task automatic expect_fields(input int r, output int eb, output int ed);
    int q;
    eb = 63; ed = 3;
    for (int d = 0; d < 4; d++) begin
      q = r >> (d + 2);
      if (d == 0 && q < 5) begin eb = 4; ed = 0; return; end
      if (q <= 64) begin eb = q - 1; ed = d; return; end
    end
  endtask

  // issue a request; returns at the negedge where done is seen
  task automatic run_calc(input int r, input string tag, input bit chk_width);
    int eb, ed, n;
    expect_fields(r, eb, ed);
    @(negedge clk); ratio = RW'(r); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 20) begin @(negedge clk); n++; end
    chk(done == 1'b1 && n == ed + 1, {tag, " latency R5"}, n, ed + 1);
    chk(int'(brg) == eb, {tag, " brg"}, brg, eb);
    chk(int'(div) == ed, {tag, " div"}, div, ed);
    if (chk_width) begin
      @(negedge clk);
      chk(done == 1'b0, {tag, " done width R5"}, done, 0);
    end
  endtask

  task automatic wait_strobe(output int k, output bit was_lead);
    k = 0; was_lead = 0;
    do begin @(negedge clk); k++; end
    while (!sck_lead && !sck_trail && k < 5000);
    was_lead = sck_lead;
  endtask

  task automatic t_reset;
    chk(brg == 6'd4, "R1 reset brg", brg, 4);
    chk(div == 2'd0, "R1 reset div", div, 0);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(!sck_lead && !sck_trail, "R1 reset strobes", sck_lead | sck_trail, 0);
  endtask

  task automatic t_search;
    run_calc(100,  "R2 ratio100", 1);
    run_calc(300,  "R2 ratio300", 1);
    run_calc(1000, "R2 ratio1000", 1);
    run_calc(2000, "R2 ratio2000", 1);
    run_calc(259,  "R2 ratio259", 1);
    run_calc(260,  "R2 ratio260", 1);
    run_calc(2079, "R2 ratio2079", 1);
  endtask

  task automatic t_fast;
    run_calc(8,  "R3 ratio8", 1);
    run_calc(19, "R3 ratio19", 1);
    run_calc(0,  "R3 ratio0", 1);
    run_calc(20, "R3 ratio20", 1);
  endtask

  task automatic t_slow;
    run_calc(2080,  "R4 ratio2080", 1);
    run_calc(60000, "R4 ratio60000", 1);
  endtask

  task automatic t_busy;
    int dn;
    @(negedge clk); ratio = RW'(2000); start = 1'b1;
    @(negedge clk); ratio = RW'(100);  // start still high: search busy now
    @(negedge clk); start = 1'b0;
    dn = 0;
    for (int i = 0; i < 12; i++) begin
      if (done) begin
        dn++;
        chk(brg == 6'd61 && div == 2'd3, "R6 busy result", {brg, div}, {6'd61, 2'd3});
      end
      @(negedge clk);
    end
    chk(dn == 1, "R6 done count", dn, 1);
  endtask

  task automatic t_strobes(input int r, input int intervals, input string tag);
    int eb, ed, h, k;
    bit ld, expect_lead;
    expect_fields(r, eb, ed);
    h = (eb + 1) * (2 << ed);
    run_calc(r, tag, 0);
    wait_strobe(k, ld);
    chk(ld == 1'b1, {tag, " first is lead R9"}, ld, 1);
    chk(k == h + 1, {tag, " first delay R9"}, k, h + 1);
    expect_lead = 0;
    for (int i = 0; i < intervals; i++) begin
      wait_strobe(k, ld);
      chk(k == h, {tag, " half period R7"}, k, h);
      chk(ld == expect_lead, {tag, " alternation R7"}, ld, expect_lead);
      expect_lead = !expect_lead;
    end
  endtask

  task automatic t_disable;
    int seen;
    @(negedge clk); en = 1'b0;
    seen = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (sck_lead || sck_trail) seen++;
    end
    chk(seen == 0, "R8 strobes while off", seen, 0);
    en = 1'b1;
    run_calc(100, "R8 after off", 0);
  endtask

  initial begin
    rst_n = 1'b0; en = 1'b0; start = 1'b0; ratio = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_search();
    t_fast();
    t_slow();
    t_busy();
    en = 1'b1;
    t_strobes(20,   4, "R10 fastest");
    t_strobes(300,  3, "R7 mid");
    t_strobes(2048, 2, "R10 slowest");
    t_disable();
    t_strobes(100,  2, "R9 after reenable");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule